// File: doc/BRIEF.md
# Programmable Dual-Modulus Prescaler

This block divides a fast input clock by one of two neighbouring ratios, P or P+1. Each output period takes one of the two lengths, and a swallow-control input picks which one, period by period. A downstream pair of pulse-swallow counters uses this to reach any overall division ratio. The base ratio P is 8, 16, 32 or 64, chosen by a two-bit select input.

The divider is fully synchronous. A four-count core repeats its count 2^k times, and k synchronous toggle stages count those repeats. In the final core pass of a period, the core may add a fifth count, which stretches that period by one input clock. The output is a pulse one input clock wide, given once per period. The downstream counters use it as their clock enable.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `swallow` low, the distance between successive `tick` pulses is 8, 16, 32 or 64 input clocks for `ratio_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R2: With `swallow` held high, every period after the first one after reset is P+1 input clocks.
- R3: `swallow` is used only in the decision cycle, which is the cycle P-1 clocks after a `tick` cycle. A high level in any other cycle of the period leaves the period at P. A high level only in the decision cycle gives P+1.
- R4: The first period after reset release is P clocks even when `swallow` is high.
- R5: `tick` is high for exactly one input clock per period.
- R6: Reset is synchronous. While `rst` is high, `tick` stays low. After release, the first `tick` appears P clocks after the cycle in which `rst` was first seen low.
- R7: `ratio_sel` is captured during reset and at each period end. A change made in the middle of a period has no effect until the period that begins at the next `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | SEL_W | Base ratio code: 0→8, 1→16, 2→32, 3→64 |
| swallow | input | 1 | High asks for a P+1 period |
| tick | output | 1 | One-clock pulse once per division period |

## Verification
The end of a period is also the edge that samples a new `ratio_sel` and arms the swallow logic. The decision cycle of one period sits one clock before that edge. The bench changes `ratio_sel` right after a pulse while `swallow` is high. It then checks that the current period keeps the old length and that the next period has the new length plus one. A separate scenario drives `swallow` high in every cycle except the decision cycle, and then only in the decision cycle. This confirms that the level in that single cycle alone decides the length.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
   typedef enum logic [1:0] {
      PS_DIV8  = 2'd0,
      PS_DIV16 = 2'd1,
      PS_DIV32 = 2'd2,
      PS_DIV64 = 2'd3
   } ps_sel_e;

   localparam int CORE_W    = 3;
   localparam int CORE_BASE = 4;

   function automatic int base_ratio(input int code);
      return CORE_BASE << (code + 1);
   endfunction
endpackage

// File: rtl/dmp_core45.sv
module dmp_core45 #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          add_one,
   output logic          wrap,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LAST4 = CW'(3);
   localparam logic [CW-1:0] LAST5 = CW'(4);

   initial begin
      if (CW < 3) $error("core counter needs at least 3 bits");
   end

   assign wrap = (cnt == LAST5) || ((cnt == LAST4) && !add_one);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/dmp_ext_chain.sv
module dmp_ext_chain #(
   parameter int SW = 2,
   parameter int N  = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic          clr,
   input  logic [SW-1:0] sel,
   output logic          last
);
   localparam int IW = $clog2(N + 1);

   logic [N-1:0] q;
   logic [N:0]   ones;
   logic [IW-1:0] k_idx;

   initial begin
      if (N < (1 << SW)) $error("extension chain shorter than select range");
   end

   assign ones[0] = 1'b1;

   for (genvar i = 0; i < N; i++) begin : g_stage
      assign ones[i+1] = ones[i] & q[i];
      always_ff @(posedge clk) begin
         if (rst || clr)          q[i] <= 1'b0;
         else if (adv && ones[i]) q[i] <= ~q[i];
      end
   end

   assign k_idx = IW'(sel) + IW'(1);
   assign last  = ones[k_idx];
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] ratio_sel,
   input  logic             swallow,
   output logic             tick
);
   import dmp_pkg::*;

   localparam int EXT_N = 1 << SEL_W;

   initial begin
      if (SEL_W < 1 || SEL_W > 3) $error("SEL_W out of supported range");
   end

   logic [SEL_W-1:0]  sel_q;
   logic              armed;
   logic              tick_q;
   logic              ext_last;
   logic              core_wrap;
   logic              add_one;
   logic              period_end;
   logic [CORE_W-1:0] core_cnt;

   assign add_one    = ext_last && swallow && armed;
   assign period_end = ext_last && core_wrap;

   dmp_core45 #(.CW(CORE_W)) u_core (
      .clk     (clk),
      .rst     (rst),
      .add_one (add_one),
      .wrap    (core_wrap),
      .cnt     (core_cnt)
   );

   dmp_ext_chain #(.SW(SEL_W), .N(EXT_N)) u_ext (
      .clk  (clk),
      .rst  (rst),
      .adv  (core_wrap),
      .clr  (period_end),
      .sel  (sel_q),
      .last (ext_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q  <= ratio_sel;
         armed  <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= period_end;
         if (period_end) begin
            sel_q <= ratio_sel;
            armed <= 1'b1;
         end
      end
   end

   assign tick = tick_q;
endmodule

// File: rtl/dmp_chk.sv
module dmp_chk (
   input logic       clk,
   input logic       rst,
   input logic       tick,
   input logic [2:0] core_cnt
);
   logic [6:0] gap;
   logic       first;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap   <= '0;
         first <= 1'b1;
      end else begin
         if (tick)               gap <= 7'd1;
         else if (gap != 7'd127) gap <= gap + 7'd1;
         if (tick) first <= 1'b0;
      end
   end

   p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   p_reset_quiet_r6: assert property (@(posedge clk)
      rst |=> !tick);

   p_gap_range_r1: assert property (@(posedge clk) disable iff (rst)
      tick |-> (gap >= 7'd8 && gap <= 7'd65));

   p_first_plain_r4: assert property (@(posedge clk) disable iff (rst)
      (tick && first) |-> ($countones(gap) == 1));

   p_core_range_r2: assert property (@(posedge clk) disable iff (rst)
      core_cnt <= 3'd4);
endmodule

bind dual_mod_prescaler dmp_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick),
   .core_cnt (core_cnt)
);

// File: tb/tb_dual_mod_prescaler.sv
module tb_dual_mod_prescaler;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] ratio_sel = 2'b00;
   logic       swallow = 1'b0;
   logic       tick;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   dual_mod_prescaler #(.SEL_W(2)) dut (
      .clk       (clk),
      .rst       (rst),
      .ratio_sel (ratio_sel),
      .swallow   (swallow),
      .tick      (tick)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ratio_of(input logic [1:0] s);
      return 8 << s;
   endfunction

   // Starts in a cycle that holds a pulse (or the first cycle after reset),
   // sampled at the falling edge. Returns the clocks until the next pulse.
   task automatic run_period(input int p, input bit mc_decide, input bit mc_other,
                             output int gap);
      int n = 0;
      gap = -1;
      for (int it = 0; it < 200; it++) begin
         swallow = (n == p - 1) ? mc_decide : mc_other;
         @(posedge clk);
         @(negedge clk);
         n++;
         if (tick) begin
            gap = n;
            break;
         end
      end
   endtask

   task automatic do_reset(input logic [1:0] s, input bit mc, input string req);
      @(negedge clk);
      rst = 1'b1;
      ratio_sel = s;
      swallow = mc;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(req, int'(tick), 0);
      end
      rst = 1'b0;
   endtask

   task automatic t_base_ratios();
      int g;
      for (int s = 0; s < 4; s++) begin
         do_reset(2'(s), 1'b0, "R6");
         run_period(ratio_of(2'(s)), 1'b0, 1'b0, g);
         check("R6", g, ratio_of(2'(s)));
         run_period(ratio_of(2'(s)), 1'b0, 1'b0, g);
         check("R1", g, ratio_of(2'(s)));
         run_period(ratio_of(2'(s)), 1'b0, 1'b0, g);
         check("R1", g, ratio_of(2'(s)));
      end
   endtask

   task automatic t_swallow_all();
      int g;
      for (int s = 0; s < 4; s++) begin
         do_reset(2'(s), 1'b1, "R6");
         run_period(ratio_of(2'(s)), 1'b1, 1'b1, g);
         check("R4", g, ratio_of(2'(s)));
         run_period(ratio_of(2'(s)), 1'b1, 1'b1, g);
         check("R2", g, ratio_of(2'(s)) + 1);
         run_period(ratio_of(2'(s)), 1'b0, 1'b0, g);
         check("R2", g, ratio_of(2'(s)));
      end
   endtask

   task automatic t_decision_point();
      int g;
      do_reset(2'b01, 1'b0, "R6");
      run_period(16, 1'b0, 1'b0, g);
      run_period(16, 1'b0, 1'b1, g);
      check("R3", g, 16);
      run_period(16, 1'b1, 1'b0, g);
      check("R3", g, 17);
      run_period(16, 1'b0, 1'b1, g);
      check("R3", g, 16);
   endtask

   task automatic t_pulse_width();
      int g;
      do_reset(2'b00, 1'b0, "R6");
      run_period(8, 1'b0, 1'b0, g);
      @(posedge clk);
      @(negedge clk);
      check("R5", int'(tick), 0);
      @(posedge clk);
      @(negedge clk);
      check("R5", int'(tick), 0);
   endtask

   task automatic t_select_change();
      int g;
      do_reset(2'b00, 1'b1, "R6");
      run_period(8, 1'b1, 1'b1, g);
      ratio_sel = 2'b10;
      run_period(8, 1'b1, 1'b1, g);
      check("R7", g, 9);
      run_period(32, 1'b1, 1'b1, g);
      check("R7", g, 33);
      ratio_sel = 2'b01;
      run_period(32, 1'b0, 1'b0, g);
      check("R7", g, 32);
      run_period(16, 1'b0, 1'b0, g);
      check("R7", g, 16);
   endtask

   initial begin
      #(20 * 20000);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_base_ratios();
      t_swallow_all();
      t_decision_point();
      t_pulse_width();
      t_select_change();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule